// File: doc/BRIEF.md
# Flash Block Protection Gate

This block sits in front of the high-voltage enable of a flash controller. It holds an 8-bit protect value that marks where a protected region begins. Every address from that point up to the top of the 16-bit space is protected. The CPU arms a program, page erase or mass erase through a small control word, then asks to raise the high-voltage enable. The gate grants that request only when four conditions hold: the operation stays out of the protected region, the protect value was read since the operation was armed, the control word names exactly one operation, and that operation matches the one already armed.

The protect value acts as non-volatile storage. Reset does not change it. A blank part holds all ones. It changes only when a completed program or erase hits the location that holds it. A bypass input stands for a high voltage on the interrupt pin. While it is high, every protection check is off. A refused request leaves the enable low and gives a one-cycle rejection pulse.

Top module: `flash_protect_gate`

## Requirements
- R1: `prot_start` equals the protect value placed in address bits [13:6], with bits [15:14] set to 1 and bits [5:0] set to 0.
- R2: With bypass low and a protect value other than 0xFF, a program or page-erase enable request is refused when the target address is at or above `prot_start`. The same request is granted when the target is below it. A value of 0x00 therefore protects 0xC000 to 0xFFFF, and 0xFF protects nothing.
- R3: With bypass low, a mass-erase enable request (erase and mass bits both set) is refused whenever the protect value is not 0xFF.
- R4: While `bypass` is high, the address and mass-erase protection checks are skipped.
- R5: An enable request is refused unless `prot_rd` was pulsed while PGM or ERASE was set. Clearing an armed PGM or ERASE forgets that read.
- R6: Control word bits are: bit0 PGM, bit1 ERASE, bit2 MASS, bit3 HVEN. An enable request is refused unless exactly one of PGM and ERASE is written, and that same bit was already set and the other bit was clear.
- R7: A refused enable request leaves `hven` at 0 and raises `reject` for exactly the cycle after the write. The control bits PGM, ERASE and MASS still take the written values.
- R8: The protect value is 0xFF at power-up and is not changed by `rst_n`.
- R9: When `op_done` pulses while HVEN and PGM are set and the target equals PROT_ADDR (0xFF7E), the protect value becomes its old value AND `op_data`.
- R10: When `op_done` pulses while HVEN and ERASE are set, the protect value returns to 0xFF for a mass erase or for a page erase of the 64-byte page holding PROT_ADDR.
- R11: `tgt_wr` is ignored while `hven` is high or while `ctl_wr` is asserted in the same cycle.
- R12: After reset, `pgm`, `erase`, `mass`, `hven` and `reject` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 4 | Control word {HVEN, MASS, ERASE, PGM} |
| tgt_wr | input | 1 | Target address write strobe |
| tgt_wdata | input | 16 | Target address |
| prot_rd | input | 1 | CPU read of the protect value |
| bypass | input | 1 | Disables all protection checks |
| op_done | input | 1 | High-voltage operation completed |
| op_data | input | 8 | Byte written by a completed program |
| pgm | output | 1 | Program armed |
| erase | output | 1 | Erase armed |
| mass | output | 1 | Mass bit of the control word |
| hven | output | 1 | High-voltage enable |
| reject | output | 1 | One-cycle pulse on a refused enable request |
| op_addr | output | 16 | Latched target address |
| prot_val | output | 8 | Stored protect value |
| prot_start | output | 16 | First protected address |

## Verification
The assertions rely on three things about the inputs. `bypass` must not change between the write that raises the enable and the cycle after it. `op_done` arrives only while the enable is already high. The target never changes in the same cycle as a control write, which the block itself enforces. Each random trial follows these rules: it fixes bypass and the target before arming, uses `op_done` only inside the sequences that set the protect value, and drops the enable before the next trial. Within those limits, the operation, the target, the protect value, bypass and whether the read is skipped are all drawn at random.

// File: rtl/flash_protect_gate.sv
module flash_protect_gate #(
  parameter int ADDR_W = 16,
  parameter int PROT_W = 8,
  parameter int PAGE_W = 6,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 16'hFF7E,
  parameter logic [PROT_W-1:0] BLANK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [3:0]        ctl_wdata,
  input  logic              tgt_wr,
  input  logic [ADDR_W-1:0] tgt_wdata,
  input  logic              prot_rd,
  input  logic              bypass,
  input  logic              op_done,
  input  logic [PROT_W-1:0] op_data,
  output logic              pgm,
  output logic              erase,
  output logic              mass,
  output logic              hven,
  output logic              reject,
  output logic [ADDR_W-1:0] op_addr,
  output logic [PROT_W-1:0] prot_val,
  output logic [ADDR_W-1:0] prot_start
);
  localparam int TOP_W = ADDR_W - PROT_W - PAGE_W;
  localparam int PAGE_HI = ADDR_W - PAGE_W;

  logic [PROT_W-1:0] prot_q = BLANK;
  logic              pgm_q, erase_q, mass_q, hven_q, rej_q, rd_ok_q;
  logic [ADDR_W-1:0] tgt_q;

  logic w_pgm, w_erase, w_mass, w_hven;
  assign w_pgm   = ctl_wdata[0];
  assign w_erase = ctl_wdata[1];
  assign w_mass  = ctl_wdata[2];
  assign w_hven  = ctl_wdata[3];

  assign prot_start = {{TOP_W{1'b1}}, prot_q, {PAGE_W{1'b0}}};

  logic prot_open, addr_hit, blocked, one_op, same_op, hven_ok, drop_op;
  assign prot_open = bypass | (&prot_q);
  // page erase: start is page-aligned, so a page reaches the region iff its base does
  assign addr_hit  = ~prot_open & (tgt_q >= prot_start);
  assign blocked   = (w_erase & w_mass) ? ~prot_open : addr_hit;
  assign one_op    = w_pgm ^ w_erase;
  assign same_op   = (w_pgm & pgm_q & ~erase_q) | (w_erase & erase_q & ~pgm_q);
  assign hven_ok   = w_hven & one_op & same_op & rd_ok_q & ~blocked;
  assign drop_op   = ctl_wr & ((pgm_q & ~w_pgm) | (erase_q & ~w_erase));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pgm_q   <= 1'b0;
      erase_q <= 1'b0;
      mass_q  <= 1'b0;
      hven_q  <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      rej_q <= ctl_wr & w_hven & ~hven_ok;
      if (ctl_wr) begin
        pgm_q   <= w_pgm;
        erase_q <= w_erase;
        mass_q  <= w_mass;
        hven_q  <= hven_ok;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          rd_ok_q <= 1'b0;
    else if (drop_op)                    rd_ok_q <= 1'b0;
    else if (prot_rd && (pgm_q || erase_q)) rd_ok_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          tgt_q <= '0;
    else if (tgt_wr && !ctl_wr && !hven_q) tgt_q <= tgt_wdata;
  end

  logic prog_hit, erase_hit;
  assign prog_hit  = op_done & hven_q & pgm_q & (tgt_q == PROT_ADDR);
  assign erase_hit = op_done & hven_q & erase_q &
                     (mass_q | (tgt_q[ADDR_W-1:PAGE_W] == PROT_ADDR[ADDR_W-1:PAGE_W]));

  always_ff @(posedge clk) begin
    if (erase_hit)     prot_q <= BLANK;
    else if (prog_hit) prot_q <= prot_q & op_data;
  end

  assign pgm      = pgm_q;
  assign erase    = erase_q;
  assign mass     = mass_q;
  assign hven     = hven_q;
  assign reject   = rej_q;
  assign op_addr  = tgt_q;
  assign prot_val = prot_q;

  logic unused_hi;
  assign unused_hi = ^PAGE_HI;
endmodule

module flash_protect_gate_chk #(
  parameter int ADDR_W = 16,
  parameter int PROT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bypass,
  input logic              pgm,
  input logic              erase,
  input logic              mass,
  input logic              hven,
  input logic              reject,
  input logic              rd_ok_q,
  input logic [ADDR_W-1:0] op_addr,
  input logic [PROT_W-1:0] prot_val,
  input logic [ADDR_W-1:0] prot_start
);
  AST_NO_PROT_HVEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hven) && !(erase && mass) |-> $past(bypass) || (&prot_val) || (op_addr < prot_start)); // R2
  AST_MASS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hven) && erase && mass |-> $past(bypass) || (&prot_val)); // R3
  AST_READ_BEFORE_HVEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hven) |-> $past(rd_ok_q)); // R5
  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    hven |-> (pgm ^ erase)); // R6
  AST_REJECT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> !hven); // R7
  AST_PROT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_val) |-> $past(hven)); // R9
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hven && $past(hven) |-> $stable(op_addr)); // R11
endmodule

bind flash_protect_gate flash_protect_gate_chk #(.ADDR_W(ADDR_W), .PROT_W(PROT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bypass(bypass), .pgm(pgm), .erase(erase), .mass(mass),
  .hven(hven), .reject(reject), .rd_ok_q(rd_ok_q), .op_addr(op_addr),
  .prot_val(prot_val), .prot_start(prot_start)
);

// File: tb/flash_protect_gate_bench.sv
module flash_protect_gate_bench;
  localparam logic [3:0] C_PGM = 4'b0001, C_ERA = 4'b0010, C_MASS = 4'b0110, C_HV = 4'b1000;
  localparam logic [15:0] PADDR = 16'hFF7E;

  logic clk = 0, rst_n = 0;
  logic ctl_wr = 0, tgt_wr = 0, prot_rd = 0, bypass = 0, op_done = 0;
  logic [3:0] ctl_wdata = 0;
  logic [15:0] tgt_wdata = 0;
  logic [7:0] op_data = 0;
  logic pgm, erase, mass, hven, reject;
  logic [15:0] op_addr, prot_start;
  logic [7:0] prot_val;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] mprot = 8'hFF;

  always #5 clk = ~clk;

  flash_protect_gate u_flash_protect_gate (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .tgt_wr(tgt_wr),
    .tgt_wdata(tgt_wdata), .prot_rd(prot_rd), .bypass(bypass), .op_done(op_done),
    .op_data(op_data), .pgm(pgm), .erase(erase), .mass(mass), .hven(hven),
    .reject(reject), .op_addr(op_addr), .prot_val(prot_val), .prot_start(prot_start)
  );

  function automatic logic [15:0] start_of(logic [7:0] p);
    return {2'b11, p, 6'b0};
  endfunction

  function automatic bit grant(int op, logic [15:0] t, logic [7:0] p, bit byp, bit rd);
    if (!rd) return 0;
    if (byp || p == 8'hFF) return 1;
    if (op == 2) return 0;
    return t < start_of(p);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(logic [3:0] d);
    @(negedge clk); ctl_wr = 1; ctl_wdata = d;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic set_tgt(logic [15:0] a);
    @(negedge clk); tgt_wr = 1; tgt_wdata = a;
    @(negedge clk); tgt_wr = 0;
  endtask

  task automatic rd_prot();
    @(negedge clk); prot_rd = 1;
    @(negedge clk); prot_rd = 0;
  endtask

  task automatic done(logic [7:0] d);
    @(negedge clk); op_done = 1; op_data = d;
    @(negedge clk); op_done = 0;
  endtask

  task automatic set_prot(logic [7:0] v);
    bypass = 1;
    set_tgt(PADDR);
    wr_ctl(C_ERA); rd_prot(); wr_ctl(C_ERA | C_HV); done(8'h00); wr_ctl(0);
    wr_ctl(C_PGM); rd_prot(); wr_ctl(C_PGM | C_HV); done(v); wr_ctl(0);
    bypass = 0;
    mprot = v;
  endtask

  task automatic trial(int op, logic [15:0] t, bit byp, bit rd, string req);
    logic [3:0] c;
    bit e;
    c = (op == 0) ? C_PGM : (op == 1) ? C_ERA : C_MASS;
    bypass = byp;
    set_tgt(t);
    wr_ctl(c);
    if (rd) rd_prot();
    wr_ctl(c | C_HV);
    e = grant(op, t, mprot, byp, rd);
    chk(req, {31'd0, hven}, {31'd0, e});
    chk({req, " R7"}, {31'd0, reject}, {31'd0, !e});
    wr_ctl(0);
    bypass = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state, R8 blank value
    chk("R12 ctl", {28'd0, hven, mass, erase, pgm}, 32'd0);
    chk("R12 reject", {31'd0, reject}, 32'd0);
    chk("R8 blank", {24'd0, prot_val}, 32'hFF);
    chk("R1 start FF", {16'd0, prot_start}, 32'hFFC0);

    // R9 program clears bits
    set_prot(8'hF0);
    chk("R9 program", {24'd0, prot_val}, 32'hF0);
    chk("R1 start F0", {16'd0, prot_start}, 32'hFC00);
    bypass = 1; set_tgt(PADDR);
    wr_ctl(C_PGM); rd_prot(); wr_ctl(C_PGM | C_HV); done(8'h3C); wr_ctl(0); bypass = 0;
    chk("R9 and", {24'd0, prot_val}, 32'h30);
    mprot = 8'h30;

    // R8 reset leaves value
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R8 keep", {24'd0, prot_val}, 32'h30);

    // R2 boundaries around start 0xCC00
    trial(0, 16'hCC00, 0, 1, "R2 at start");
    trial(0, 16'hCBFF, 0, 1, "R2 below start");
    trial(1, 16'hCBC0, 0, 1, "R2 page below");
    trial(1, 16'hFFFF, 0, 1, "R2 top");
    trial(2, 16'h0000, 0, 1, "R3 mass");
    trial(2, 16'h0000, 1, 1, "R4 mass bypass");
    trial(0, 16'hFFFF, 1, 1, "R4 pgm bypass");
    trial(0, 16'h1000, 0, 0, "R5 no read");

    // R5 cleared by dropping op
    set_tgt(16'h1000);
    wr_ctl(C_PGM); rd_prot(); wr_ctl(0); wr_ctl(C_PGM); wr_ctl(C_PGM | C_HV);
    chk("R5 flag lost", {30'd0, hven, reject}, 32'd1);
    wr_ctl(0);
    // R5 read while idle does not count
    rd_prot(); wr_ctl(C_PGM); wr_ctl(C_PGM | C_HV);
    chk("R5 idle read", {30'd0, hven, reject}, 32'd1);
    chk("R7 bits kept", {29'd0, mass, erase, pgm}, 32'd1);
    wr_ctl(0);
    // R6 both ops / unarmed op
    wr_ctl(C_PGM); rd_prot(); wr_ctl(C_PGM | C_ERA | C_HV);
    chk("R6 both", {30'd0, hven, reject}, 32'd1);
    wr_ctl(0);
    wr_ctl(C_PGM); rd_prot(); wr_ctl(C_ERA | C_HV);
    chk("R6 switch", {30'd0, hven, reject}, 32'd1);
    wr_ctl(0);
    @(negedge clk);
    chk("R7 pulse ends", {31'd0, reject}, 32'd0);

    // R11 target held while hven high, and same-cycle ignore
    set_tgt(16'h2000);
    wr_ctl(C_PGM); rd_prot(); wr_ctl(C_PGM | C_HV);
    chk("R11 setup", {31'd0, hven}, 32'd1);
    set_tgt(16'hFF00);
    chk("R11 held", {16'd0, op_addr}, 32'h2000);
    wr_ctl(0);
    @(negedge clk); ctl_wr = 1; ctl_wdata = 0; tgt_wr = 1; tgt_wdata = 16'h4444;
    @(negedge clk); ctl_wr = 0; tgt_wr = 0;
    chk("R11 same cycle", {16'd0, op_addr}, 32'h2000);

    // R10 page erase restores when page open, refused when covered
    set_prot(8'hFE);
    chk("R1 start FE", {16'd0, prot_start}, 32'hFF80);
    set_tgt(16'hFF40);
    wr_ctl(C_ERA); rd_prot(); wr_ctl(C_ERA | C_HV);
    chk("R10 page open", {31'd0, hven}, 32'd1);
    done(8'h00); wr_ctl(0);
    chk("R10 restored", {24'd0, prot_val}, 32'hFF);
    mprot = 8'hFF;
    set_prot(8'hFD);
    trial(1, 16'hFF40, 0, 1, "R10 page covered");
    chk("R10 kept", {24'd0, prot_val}, 32'hFD);
    set_prot(8'hFF);
    wr_ctl(C_MASS); rd_prot(); wr_ctl(C_MASS | C_HV);
    chk("R3 mass open", {31'd0, hven}, 32'd1);
    done(8'h00); wr_ctl(0);
    chk("R10 mass", {24'd0, prot_val}, 32'hFF);

    // R2 whole range with 0x00
    set_prot(8'h00);
    chk("R1 start 00", {16'd0, prot_start}, 32'hC000);
    trial(0, 16'hC000, 0, 1, "R2 zero base");
    trial(0, 16'hBFFF, 0, 1, "R2 zero below");

    // random
    for (int i = 0; i < 300; i++) begin
      int op;
      logic [15:0] t;
      if (i % 20 == 0) begin
        int k;
        logic [7:0] v;
        k = $urandom % 4;
        v = (k == 0) ? 8'hFF : (k == 1) ? 8'h00 : 8'($urandom);
        set_prot(v);
        chk("R1 random", {16'd0, prot_start}, {16'd0, start_of(v)});
      end
      op = $urandom % 3;
      t = ($urandom % 2) ? {2'b11, 14'($urandom)} : 16'($urandom);
      trial(op, t, ($urandom % 6) == 0, ($urandom % 8) != 0, "R2 random");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule